// File: doc/BRIEF.md
# Packet-Driven DRAM Command Sequencer

This block sits on the memory-module side of a narrow command link. Each memory access arrives as one self-contained command packet, delivered a few bits per clock on a set of parallel lanes and qualified by a valid strobe. Once a packet is complete, the block holds its fields. It then produces the whole DRAM command sequence by itself: one row activate, then a run of column read or write commands. The packet states how many column commands to issue, so a single packet can stream a long burst. The block sees no fixed transfer size.

The block drives a 25-bit address/control bus toward the DRAM devices. It also opens a data window on the 64-bit data path, pointing that path toward the devices for writes or back toward the link for reads. The window is placed a fixed CAS latency after each column command. The default timing follows a DDR3 10-10-10 part: 10 clocks from activate to column command, and 10 clocks from column command to data. Column commands inside one burst are spaced 4 clocks apart. The block accepts no new packet until the current burst has fully drained.

The sequencer has six states:
- IDLE: collecting beats.
- ACTIVATE: one cycle.
- RCD_WAIT: waiting for the activate-to-column delay.
- COLUMN: one cycle per column command.
- CCD_GAP: spacing between column commands.
- DRAIN: waiting out the last data window.

Its transitions are:
- IDLE→ACTIVATE on the final packet beat.
- ACTIVATE→RCD_WAIT always.
- RCD_WAIT→COLUMN when the delay counter expires.
- COLUMN→CCD_GAP while commands remain.
- COLUMN→DRAIN after the last command.
- CCD_GAP→COLUMN on counter expiry.
- DRAIN→IDLE on counter expiry.

Top module: `pktcmd_dram_rx`

## Requirements
- R1: A packet is 36 bits sent most significant bit first, 4 bits per beat, over 9 beats with `cmd_valid` high; within a beat lane 3 carries the earliest bit. From first to last, the fields are: burst count (8 bits), bank (3 bits), start column (10 bits), row (14 bits), then a direction bit (1 = write).
- R2: `dram_ca` is laid out as follows:
  - [24:21] = {cs_n, ras_n, cas_n, we_n}, with NOP = 0111, ACTIVATE = 0011, READ = 0101, WRITE = 0100.
  - [20:18] = bank.
  - [17:2] = 16-bit address.
  - [1] = termination enable.
  - [0] = clock enable, which is always 1.
- R3: In the cycle after the clock edge that takes the final beat, the bus shows ACTIVATE with the packet's bank and the row on address bits [13:0]; the upper address bits are 0.
- R4: The first column command appears TRCD (10) cycles after ACTIVATE. A burst count of b yields exactly b+1 column commands, spaced TCCD (4) cycles apart. Each is READ or WRITE according to the direction bit and carries the packet's bank.
- R5: The i-th column command (from 0) carries (start column + 8·i) mod 1024 on address bits [9:0]. Address bit 10 (auto-precharge) is 1 only on the last column command, and bits [15:11] are 0.
- R6: Each column command opens a data window from CL (10) cycles after it, lasting TCCD cycles. For a write, `dq_oe` and the termination bit are high in the window and `dq_out` equals `wr_data`. For a read, `rd_valid` is high in the window and `rd_data` equals `dq_in`. Outside windows, `dq_oe`, `rd_valid` and the termination bit are 0.
- R7: In every NOP cycle the bank and address fields of `dram_ca` are 0.
- R8: `cmd_ready` is high only in IDLE. It goes low from the ACTIVATE cycle and returns high CL+TCCD cycles after the last column command. Beats presented while `cmd_ready` is low are ignored and do not disturb the next packet.
- R9: After reset `cmd_ready` is 1, the bus shows NOP with zero bank and address, and `dq_oe` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command beat strobe |
| cmd_lanes | input | 4 | Command beat bits |
| cmd_ready | output | 1 | High while a new packet can be collected |
| dram_ca | output | 25 | DRAM address/control bus |
| dq_out | output | 64 | Write data toward the DRAM |
| dq_oe | output | 1 | Data path points toward the DRAM |
| dq_in | input | 64 | Read data from the DRAM |
| wr_data | input | 64 | Write data from the link |
| rd_data | output | 64 | Read data toward the link |
| rd_valid | output | 1 | Read data window active |

## Verification
Packets are swept across all burst-count lengths from one to four column commands, then eight and the maximum of 256, in both directions and for every bank value. This separates errors in command count, spacing and window length, which all scale with the burst count. The field values are chosen to tell the fields apart: all-zero, all-one, alternating-bit rows, and start columns near 1024. These expose lane-order and field-boundary slips, as well as missing column wraparound. One packet is sent while junk beats stream in during the previous burst, so a receiver that takes beats while busy corrupts the following access.

// File: rtl/pktcmd_pkg.sv
package pktcmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACTIVATE,
        S_RCD_WAIT,
        S_COLUMN,
        S_CCD_GAP,
        S_DRAIN
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_ACT   = 4'b0011;
    localparam logic [3:0] CMD_READ  = 4'b0101;
    localparam logic [3:0] CMD_WRITE = 4'b0100;

endpackage

// File: rtl/pktcmd_deser.sv
module pktcmd_deser #(
    parameter int LANES = 4,
    parameter int PKT_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             beat_valid,
    input  logic [LANES-1:0] beat,
    output logic             pkt_done,
    output logic [PKT_W-1:0] pkt
);
    localparam int BEATS = (PKT_W + LANES - 1) / LANES;
    localparam int SR_W  = BEATS * LANES;
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [SR_W-LANES-1:0] hold_q;
    logic [SR_W-1:0]       word;
    logic [CNT_W-1:0]      beat_cnt_q;

    // Earlier beats sit in the upper bits; the live beat completes the word.
    assign word     = {hold_q, beat};
    assign pkt      = word[PKT_W-1:0];
    assign pkt_done = en && beat_valid && (beat_cnt_q == CNT_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            beat_cnt_q <= '0;
        end else if (en && beat_valid) begin
            hold_q     <= word[SR_W-LANES-1:0];
            beat_cnt_q <= pkt_done ? '0 : beat_cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pktcmd_seq.sv
module pktcmd_seq
    import pktcmd_pkg::*;
#(
    parameter int BL_W     = 8,
    parameter int BANK_W   = 3,
    parameter int COL_W    = 10,
    parameter int ROW_W    = 14,
    parameter int ADDR_W   = 16,
    parameter int AP_BIT   = 10,
    parameter int COL_STEP = 8,
    parameter int TRCD     = 10,
    parameter int TCCD     = 4,
    parameter int CL       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_done,
    input  logic [BL_W-1:0]   burst_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              wr_i,
    output logic [3:0]        cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr,
    output logic              col_pulse,
    output logic              is_wr,
    output logic              ready
);
    localparam int DRAIN_LEN = CL + TCCD;
    localparam int WAIT_MAX  = (TRCD > DRAIN_LEN) ? TRCD : DRAIN_LEN;
    localparam int CNT_W     = $clog2(WAIT_MAX + 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BL_W-1:0]   rem_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic              wr_q;
    logic              last_col;

    assign last_col = (rem_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (pkt_done) state_d = S_ACTIVATE;
            S_ACTIVATE: state_d = S_RCD_WAIT;
            S_RCD_WAIT: if (cnt_q == '0) state_d = S_COLUMN;
            S_COLUMN:   state_d = last_col ? S_DRAIN : S_CCD_GAP;
            S_CCD_GAP:  if (cnt_q == '0) state_d = S_COLUMN;
            S_DRAIN:    if (cnt_q == '0) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Latched packet fields and timing counters
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rem_q  <= '0;
            bank_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            wr_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (pkt_done) begin
                    rem_q  <= burst_i;
                    bank_q <= bank_i;
                    col_q  <= col_i;
                    row_q  <= row_i;
                    wr_q   <= wr_i;
                end
                S_ACTIVATE: cnt_q <= CNT_W'(TRCD - 2);
                S_COLUMN: begin
                    col_q <= col_q + COL_W'(COL_STEP);
                    rem_q <= rem_q - BL_W'(1);
                    cnt_q <= last_col ? CNT_W'(DRAIN_LEN - 2) : CNT_W'(TCCD - 2);
                end
                S_RCD_WAIT, S_CCD_GAP, S_DRAIN:
                    if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd  = CMD_NOP;
        bank = '0;
        addr = '0;
        unique case (state_q)
            S_ACTIVATE: begin
                cmd              = CMD_ACT;
                bank             = bank_q;
                addr[ROW_W-1:0]  = row_q;
            end
            S_COLUMN: begin
                cmd              = wr_q ? CMD_WRITE : CMD_READ;
                bank             = bank_q;
                addr[COL_W-1:0]  = col_q;
                addr[AP_BIT]     = last_col;
            end
            default: ;
        endcase
    end

    assign col_pulse = (state_q == S_COLUMN);
    assign ready     = (state_q == S_IDLE);
    assign is_wr     = wr_q;
endmodule

// File: rtl/pktcmd_dwin.sv
module pktcmd_dwin #(
    parameter int CL   = 10,
    parameter int TCCD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic col_pulse,
    input  logic is_wr,
    output logic wr_win,
    output logic rd_win
);
    localparam int HIST_W = CL + TCCD - 1;

    // hist_q[i] is set when a column command was issued i+1 cycles ago.
    logic [HIST_W-1:0] hist_q;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[HIST_W-2:0], col_pulse};
    end

    assign active = |hist_q[HIST_W-1:CL-1];
    assign wr_win = active && is_wr;
    assign rd_win = active && !is_wr;
endmodule

// File: rtl/pktcmd_dram_rx.sv
module pktcmd_dram_rx #(
    parameter int LANES    = 4,
    parameter int BL_W     = 8,
    parameter int BANK_W   = 3,
    parameter int COL_W    = 10,
    parameter int ROW_W    = 14,
    parameter int ADDR_W   = 16,
    parameter int DQ_W     = 64,
    parameter int TRCD     = 10,
    parameter int TCCD     = 4,
    parameter int CL       = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [LANES-1:0]           cmd_lanes,
    output logic                       cmd_ready,
    output logic [BANK_W+ADDR_W+5:0]   dram_ca,
    output logic [DQ_W-1:0]            dq_out,
    output logic                       dq_oe,
    input  logic [DQ_W-1:0]            dq_in,
    input  logic [DQ_W-1:0]            wr_data,
    output logic [DQ_W-1:0]            rd_data,
    output logic                       rd_valid
);
    localparam int PKT_W  = BL_W + BANK_W + COL_W + ROW_W + 1;
    localparam int ROW_LO = 1;
    localparam int COL_LO = ROW_LO + ROW_W;
    localparam int BNK_LO = COL_LO + COL_W;
    localparam int BL_LO  = BNK_LO + BANK_W;

    logic [PKT_W-1:0]  pkt;
    logic              pkt_done;
    logic [3:0]        cmd;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    logic              col_pulse, is_wr, wr_win, rd_win;

    pktcmd_deser #(.LANES(LANES), .PKT_W(PKT_W)) u_deser (
        .clk(clk), .rst(rst), .en(cmd_ready), .beat_valid(cmd_valid),
        .beat(cmd_lanes), .pkt_done(pkt_done), .pkt(pkt)
    );

    pktcmd_seq #(
        .BL_W(BL_W), .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W),
        .ADDR_W(ADDR_W), .AP_BIT(10), .COL_STEP(8),
        .TRCD(TRCD), .TCCD(TCCD), .CL(CL)
    ) u_seq (
        .clk(clk), .rst(rst), .pkt_done(pkt_done),
        .burst_i(pkt[BL_LO +: BL_W]),
        .bank_i (pkt[BNK_LO +: BANK_W]),
        .col_i  (pkt[COL_LO +: COL_W]),
        .row_i  (pkt[ROW_LO +: ROW_W]),
        .wr_i   (pkt[0]),
        .cmd(cmd), .bank(bank), .addr(addr),
        .col_pulse(col_pulse), .is_wr(is_wr), .ready(cmd_ready)
    );

    pktcmd_dwin #(.CL(CL), .TCCD(TCCD)) u_dwin (
        .clk(clk), .rst(rst), .col_pulse(col_pulse), .is_wr(is_wr),
        .wr_win(wr_win), .rd_win(rd_win)
    );

    assign dram_ca  = {cmd, bank, addr, wr_win, 1'b1};
    assign dq_out   = wr_data;
    assign dq_oe    = wr_win;
    assign rd_data  = dq_in;
    assign rd_valid = rd_win;
endmodule

// File: rtl/pktcmd_dram_rx_chk.sv
module pktcmd_dram_rx_chk #(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_ready,
    input logic [BANK_W+ADDR_W+5:0] dram_ca,
    input logic                     dq_oe,
    input logic                     rd_valid
);
    localparam int TOP = BANK_W + ADDR_W + 5;
    logic [3:0] cmd;
    assign cmd = dram_ca[TOP -: 4];

    p_act_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0011) |-> $past(cmd_ready));
    p_busy_on_act_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0011) |-> !cmd_ready);
    p_act_then_nop_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0011) |=> (dram_ca[TOP -: 4] == 4'b0111));
    p_nop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0111) |-> (dram_ca[TOP-4:2] == '0));
    p_dir_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(dq_oe && rd_valid));
    p_window_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (dq_oe || rd_valid) |-> !cmd_ready);
endmodule

bind pktcmd_dram_rx pktcmd_dram_rx_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .dram_ca(dram_ca),
    .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/pktcmd_dram_rx_bench.sv
module pktcmd_dram_rx_bench;
    localparam int CLK_P = 10;
    localparam int TRCD  = 10;
    localparam int TCCD  = 4;
    localparam int CL    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_lanes = '0;
    logic        cmd_ready;
    logic [24:0] dram_ca;
    logic [63:0] dq_out, dq_in = '0, wr_data = '0, rd_data;
    logic        dq_oe, rd_valid;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_P/2) clk = ~clk;

    pktcmd_dram_rx #(.TRCD(TRCD), .TCCD(TCCD), .CL(CL)) u_pktcmd_dram_rx (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_lanes(cmd_lanes),
        .cmd_ready(cmd_ready), .dram_ca(dram_ca), .dq_out(dq_out), .dq_oe(dq_oe),
        .dq_in(dq_in), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic cmp(input string req, input int k, input logic [63:0] got, input logic [63:0] exp);
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d got %h expected %h", req, k, got, exp);
        end
    endtask

    // R1: 36-bit packet, MSB first, lane 3 first within a beat
    task automatic send_pkt(input int bl, input int bk, input int col, input int row, input bit wr);
        logic [35:0] p;
        p = {8'(bl), 3'(bk), 10'(col), 14'(row), wr};
        for (int b = 0; b < 9; b++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_lanes = p[35 - 4*b -: 4];
            @(posedge clk);
        end
    endtask

    task automatic run_check(input int bl, input int bk, input int col, input int row,
                             input bit wr, input bit junk);
        int n, stop, i, win_lo, win_hi;
        logic [3:0]  ecmd;
        logic [2:0]  ebank;
        logic [15:0] eaddr;
        bit          win;
        n      = bl + 1;
        stop   = TRCD + (n - 1) * TCCD + CL + TCCD;
        win_lo = TRCD + CL;
        win_hi = TRCD + CL + n * TCCD;
        for (int k = 0; k <= stop; k++) begin
            @(negedge clk);
            wr_data   = {32'(k * 7 + 3), 32'(~k)};
            dq_in     = {32'(k ^ 32'h5a5a), 32'(k * 13)};
            cmd_valid = junk && (k < stop);
            cmd_lanes = 4'(k * 5 + 1);
            #1;
            vectors++;
            ecmd = 4'b0111; ebank = '0; eaddr = '0;
            if (k == 0) begin
                ecmd = 4'b0011; ebank = 3'(bk); eaddr = 16'(row);      // R3
            end else if (k >= TRCD && ((k - TRCD) % TCCD) == 0 && ((k - TRCD) / TCCD) < n) begin
                i = (k - TRCD) / TCCD;                                  // R4
                ecmd  = wr ? 4'b0100 : 4'b0101;
                ebank = 3'(bk);
                eaddr = 16'((col + 8 * i) % 1024);                      // R5
                if (i == n - 1) eaddr[10] = 1'b1;
            end
            win = (k >= win_lo) && (k < win_hi);
            cmp("R2/R4/R5/R7 bus", k, 64'(dram_ca),
                64'({ecmd, ebank, eaddr, win && wr, 1'b1}));
            cmp("R6 dq_oe", k, 64'(dq_oe), 64'(win && wr));
            cmp("R6 rd_valid", k, 64'(rd_valid), 64'(win && !wr));
            if (win && wr)  cmp("R6 write data", k, dq_out, wr_data);
            if (win && !wr) cmp("R6 read data", k, rd_data, dq_in);
            cmp("R8 cmd_ready", k, 64'(cmd_ready), 64'(k == stop));
        end
        cmd_valid = 1'b0;
    endtask

    task automatic one(input int bl, input int bk, input int col, input int row,
                       input bit wr, input bit junk);
        send_pkt(bl, bk, col, row, wr);
        run_check(bl, bk, col, row, wr, junk);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        vectors++;  // R9 reset state
        cmp("R9 ready", 0, 64'(cmd_ready), 64'd1);
        cmp("R9 bus", 0, 64'(dram_ca), 64'({4'b0111, 3'd0, 16'd0, 1'b0, 1'b1}));
        cmp("R9 dq_oe", 0, 64'(dq_oe), 64'd0);
        cmp("R9 rd_valid", 0, 64'(rd_valid), 64'd0);

        one(0,   0, 0,    0,       1'b0, 1'b0);   // R1 all zero
        one(0,   7, 1023, 16383,   1'b1, 1'b0);   // R1 all ones
        one(1,   3, 1020, 14'h2AAA, 1'b0, 1'b0);  // R5 wrap
        one(2,   5, 1016, 14'h1555, 1'b1, 1'b1);  // R8 junk beats while busy
        one(3,   1, 8,    100,     1'b0, 1'b1);   // R8 after junk
        one(7,   2, 1,    5,       1'b1, 1'b0);
        one(255, 6, 4,    14'h3FFF, 1'b0, 1'b0);  // R4 maximum burst
        for (int b = 0; b < 8; b++)
            one(1, b, 64 * b + 3, 1000 * b + 7, b[0], b[1]);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule